// File: doc/BRIEF.md
# IDE Bus-Master DMA Transfer Sequencer

This block steers one IDE bus-master DMA transfer that a scatter-gather channel delivers in pieces. A start pulse sets up the byte count still owed, clears the running buffer position, captures the logical block address and drive kind, and arms the sequencer. After that, the channel offers one descriptor piece at a time. For each piece the sequencer does one of two things. It may give an immediate verdict: the piece waits for a restart, the piece is over, or the transfer is over. Otherwise it issues one storage request carrying the byte offset into the medium. It then waits for that request to finish or fail.

Disk and optical drives differ in two ways. They use different block sizes when the address is turned into a byte offset, and they finish with different status codes. For an optical command that is not block based, marked by an all-ones address, the request is a copy out of the drive's internal buffer. That copy is clipped to the bytes still owed, and it always finishes the transfer. A drive interrupt goes with every final status. It stays high until the host reads the status.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset, `status_o` is 0x00, `irq_o` is low, `chunk_done_o` and `io_req_o` are low, and `chunk_ready_o` is high.
- R2: A `start_i` pulse sets the bytes owed to `sectors_i`×512 when `optical_i` is 0, or to `packet_bytes_i` when it is 1. It clears the buffer position to 0, captures `lba_i`, and arms the sequencer. A disk transfer then needs exactly ceil(bytes owed / piece length) non-empty pieces to finish.
- R3: A piece offered while the sequencer is not armed gets `chunk_code_o`=0 (wait for restart). It issues no request and leaves status and interrupt unchanged.
- R4: For a disk, a non-empty piece issues a request with `io_offset_o` = (captured LBA << 9) + buffer position, `io_len_o` = piece length, `io_addr_o` = piece address and `io_copy_o`=0. The request stays up until `io_done_i` or `io_err_i`.
- R5: For an optical drive with a block address, the request offset is (captured LBA << 11) + buffer position.
- R6: When a block request completes, the bytes owed shrink by the piece length, saturating at zero, and the buffer position grows by the piece length. If bytes are still owed, `chunk_code_o`=1 (piece over); if none are, the transfer finishes with code 2.
- R7: A zero-length piece while armed with bytes owed gives code 1 at once, with no request and no change of state.
- R8: A finished disk transfer sets `status_o` to 0x50 (ready bit 6, seek bit 4), raises `irq_o` and disarms the sequencer.
- R9: A finished optical transfer sets `status_o` to 0x40 (ready bit 6 only), raises `irq_o` and disarms the sequencer.
- R10: For an optical drive with an LBA of all ones, a non-empty piece issues a copy request (`io_copy_o`=1, `io_offset_o`=0) of min(bytes owed, piece length). Its completion finishes the transfer as in R9.
- R11: `io_err_i` during a request sets `status_o` to 0x41 (ready bit 6, error bit 0), raises `irq_o`, gives code 3 and disarms the sequencer.
- R12: `irq_o` stays high until a cycle with `status_rd_i`. If a new final status arrives in the same cycle as the read, the interrupt stays high.
- R13: A piece offered while armed with zero bytes owed finishes the transfer at once, with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin or restart a transfer (taken when idle) |
| optical_i | input | 1 | Drive kind for this transfer: 1 optical, 0 disk |
| sectors_i | input | SEC_W | Disk sector count |
| packet_bytes_i | input | PKT_W | Optical packet transfer size in bytes |
| lba_i | input | LBA_W | Starting logical block address |
| chunk_valid_i | input | 1 | A descriptor piece is offered |
| chunk_ready_o | output | 1 | Sequencer can take a piece this cycle |
| chunk_addr_i | input | ADDR_W | Memory address of the piece |
| chunk_len_i | input | LEN_W | Piece length in bytes |
| chunk_done_o | output | 1 | One-cycle verdict pulse for the current piece |
| chunk_code_o | output | 2 | Verdict: 0 wait, 1 piece over, 2 transfer over, 3 error |
| io_req_o | output | 1 | Storage request outstanding |
| io_copy_o | output | 1 | Request is a copy from the drive buffer |
| io_addr_o | output | ADDR_W | Memory address of the request |
| io_offset_o | output | OFF_W | Byte offset into the medium |
| io_len_o | output | LEN_W | Request length in bytes |
| io_done_i | input | 1 | Request completed |
| io_err_i | input | 1 | Request failed |
| status_o | output | 8 | Drive status byte |
| irq_o | output | 1 | Drive interrupt |
| status_rd_i | input | 1 | Host status read, clears the interrupt |

## Verification
Disk transfers of one to three sectors are swept against three piece patterns. Whole-sector pieces test the plain offset arithmetic. 300-byte pieces leave an unaligned buffer position and an oversized last piece, which tests the saturation of the bytes owed. Alternating empty and 700-byte pieces show that an empty piece changes nothing. Optical runs with 100, 2048 and 5000 packet bytes check the larger offset shift and the different final status. All-ones addresses with packets shorter and longer than the piece check the clipping of the copy. Separate runs cover a zero-sector start, an injected request error, a piece offered after disarming, and a status read in the same cycle as a new completion. Together these tell apart wrong verdicts, wrong status codes and a lost interrupt.

// File: rtl/ide_dma_seq_pkg.sv
package ide_dma_seq_pkg;

  typedef enum logic [1:0] {
    CODE_WAIT = 2'd0,
    CODE_NEXT = 2'd1,
    CODE_FIN  = 2'd2,
    CODE_FAIL = 2'd3
  } piece_code_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_BUSY = 1'b1
  } sq_state_e;

  localparam int unsigned DISK_SHIFT = 9;
  localparam int unsigned OPT_SHIFT  = 11;

  localparam logic [7:0] STS_DISK_OK = 8'h50;
  localparam logic [7:0] STS_OPT_OK  = 8'h40;
  localparam logic [7:0] STS_FAULT   = 8'h41;

endpackage

// File: rtl/ide_dma_seq_track.sv
module ide_dma_seq_track #(
  parameter int unsigned SEC_W  = 8,
  parameter int unsigned PKT_W  = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LBA_W  = 20,
  parameter int unsigned SIZE_W = 17,
  parameter int unsigned IDX_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              opt_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [PKT_W-1:0]  pkt_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  step_len_i,
  input  logic              stop_i,
  output logic [SIZE_W-1:0] rem_o,
  output logic [SIZE_W-1:0] rem_left_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LBA_W-1:0]  lba_o,
  output logic              opt_o,
  output logic              act_o
);
  logic [SIZE_W-1:0] rem_q, rem_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LBA_W-1:0]  lba_q, lba_d;
  logic              opt_q, opt_d, act_q, act_d, en;
  logic [SIZE_W-1:0] len_ext;

  always_comb begin
    len_ext    = SIZE_W'(step_len_i);
    rem_left_o = (len_ext >= rem_q) ? '0 : rem_q - len_ext;
  end

  always_comb begin
    en    = load_i | step_i | stop_i;
    rem_d = rem_q;
    idx_d = idx_q;
    lba_d = lba_q;
    opt_d = opt_q;
    act_d = act_q;
    if (load_i) begin
      rem_d = opt_i ? SIZE_W'(pkt_i) : SIZE_W'({sec_i, 9'd0});
      idx_d = '0;
      lba_d = lba_i;
      opt_d = opt_i;
      act_d = 1'b1;
    end else begin
      if (step_i) begin
        rem_d = rem_left_o;
        idx_d = idx_q + IDX_W'(step_len_i);
      end
      if (stop_i) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
      lba_q <= '0;
      opt_q <= 1'b0;
      act_q <= 1'b0;
    end else if (en) begin
      rem_q <= rem_d;
      idx_q <= idx_d;
      lba_q <= lba_d;
      opt_q <= opt_d;
      act_q <= act_d;
    end
  end

  assign rem_o = rem_q;
  assign idx_o = idx_q;
  assign lba_o = lba_q;
  assign opt_o = opt_q;
  assign act_o = act_q;
endmodule

// File: rtl/ide_dma_seq_addr.sv
module ide_dma_seq_addr
  import ide_dma_seq_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LBA_W  = 20,
  parameter int unsigned SIZE_W = 17,
  parameter int unsigned IDX_W  = 18,
  parameter int unsigned OFF_W  = 32
) (
  input  logic              opt_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SIZE_W-1:0] rem_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [OFF_W-1:0]  offset_o,
  output logic              raw_o,
  output logic [LEN_W-1:0]  copy_len_o
);
  logic [OFF_W-1:0]  base;
  logic [SIZE_W-1:0] len_ext;

  always_comb begin
    base       = opt_i ? (OFF_W'(lba_i) << OPT_SHIFT) : (OFF_W'(lba_i) << DISK_SHIFT);
    offset_o   = base + OFF_W'(idx_i);
    raw_o      = opt_i & (&lba_i);
    len_ext    = SIZE_W'(len_i);
    copy_len_o = (len_ext <= rem_i) ? len_i : LEN_W'(rem_i);
  end
endmodule

// File: rtl/ide_dma_seq_stat.sv
module ide_dma_seq_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_i,
  input  logic [7:0] code_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic [7:0] sts_q, sts_d;
  logic       irq_q, irq_d;

  always_comb begin
    sts_d = set_i ? code_i : sts_q;
    irq_d = set_i ? 1'b1 : (rd_i ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 8'h00;
      irq_q <= 1'b0;
    end else begin
      if (set_i) sts_q <= sts_d;
      if (set_i | rd_i) irq_q <= irq_d;
    end
  end

  assign status_o = sts_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
  import ide_dma_seq_pkg::*;
#(
  parameter int unsigned SEC_W  = 8,
  parameter int unsigned PKT_W  = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LBA_W  = 20,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned SIZE_W = ((SEC_W + 9) > PKT_W) ? (SEC_W + 9) : PKT_W,
  localparam int unsigned IDX_W  = SIZE_W + 1,
  localparam int unsigned OFF_W  = LBA_W + OPT_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              optical_i,
  input  logic [SEC_W-1:0]  sectors_i,
  input  logic [PKT_W-1:0]  packet_bytes_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic              chunk_valid_i,
  output logic              chunk_ready_o,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  output logic              chunk_done_o,
  output logic [1:0]        chunk_code_o,
  output logic              io_req_o,
  output logic              io_copy_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [OFF_W-1:0]  io_offset_o,
  output logic [LEN_W-1:0]  io_len_o,
  input  logic              io_done_i,
  input  logic              io_err_i,
  output logic [7:0]        status_o,
  output logic              irq_o,
  input  logic              status_rd_i
);
  sq_state_e         state_q, state_d;
  logic              req_q, req_d, copy_q, copy_d, done_q, done_d;
  piece_code_e       code_q, code_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [LEN_W-1:0]  len_q, len_d;

  logic              load, step, stop, fin, take, idle;
  logic [7:0]        fin_code;
  logic [SIZE_W-1:0] rem, rem_left;
  logic [IDX_W-1:0]  idx;
  logic [LBA_W-1:0]  lba;
  logic              opt, act, raw;
  logic [OFF_W-1:0]  offset;
  logic [LEN_W-1:0]  copy_len;

  ide_dma_seq_track #(
    .SEC_W(SEC_W), .PKT_W(PKT_W), .LEN_W(LEN_W), .LBA_W(LBA_W),
    .SIZE_W(SIZE_W), .IDX_W(IDX_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .load_i(load), .opt_i(optical_i),
    .sec_i(sectors_i), .pkt_i(packet_bytes_i), .lba_i(lba_i),
    .step_i(step), .step_len_i(len_q), .stop_i(stop),
    .rem_o(rem), .rem_left_o(rem_left), .idx_o(idx), .lba_o(lba),
    .opt_o(opt), .act_o(act)
  );

  ide_dma_seq_addr #(
    .LEN_W(LEN_W), .LBA_W(LBA_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_addr (
    .opt_i(opt), .lba_i(lba), .idx_i(idx), .rem_i(rem), .len_i(chunk_len_i),
    .offset_o(offset), .raw_o(raw), .copy_len_o(copy_len)
  );

  ide_dma_seq_stat u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(fin), .code_i(fin_code),
    .rd_i(status_rd_i), .status_o(status_o), .irq_o(irq_o)
  );

  assign idle          = (state_q == SQ_IDLE);
  assign chunk_ready_o = idle & ~start_i;

  always_comb begin
    state_d  = state_q;
    req_d    = req_q;
    copy_d   = copy_q;
    addr_d   = addr_q;
    off_d    = off_q;
    len_d    = len_q;
    code_d   = code_q;
    done_d   = 1'b0;
    step     = 1'b0;
    stop     = 1'b0;
    fin      = 1'b0;
    fin_code = opt ? STS_OPT_OK : STS_DISK_OK;
    load     = idle & start_i;
    take     = chunk_valid_i & chunk_ready_o;

    unique case (state_q)
      SQ_IDLE: begin
        if (take) begin
          if (!act) begin
            done_d = 1'b1;
            code_d = CODE_WAIT;
          end else if (rem == '0) begin
            done_d = 1'b1;
            code_d = CODE_FIN;
            stop   = 1'b1;
            fin    = 1'b1;
          end else if (chunk_len_i == '0) begin
            done_d = 1'b1;
            code_d = CODE_NEXT;
          end else begin
            req_d   = 1'b1;
            addr_d  = chunk_addr_i;
            state_d = SQ_BUSY;
            copy_d  = raw;
            off_d   = raw ? '0 : offset;
            len_d   = raw ? copy_len : chunk_len_i;
          end
        end
      end
      SQ_BUSY: begin
        if (io_err_i) begin
          req_d    = 1'b0;
          state_d  = SQ_IDLE;
          done_d   = 1'b1;
          code_d   = CODE_FAIL;
          stop     = 1'b1;
          fin      = 1'b1;
          fin_code = STS_FAULT;
        end else if (io_done_i) begin
          req_d   = 1'b0;
          state_d = SQ_IDLE;
          done_d  = 1'b1;
          if (copy_q) begin
            code_d = CODE_FIN;
            stop   = 1'b1;
            fin    = 1'b1;
          end else begin
            step = 1'b1;
            if (rem_left == '0) begin
              code_d = CODE_FIN;
              stop   = 1'b1;
              fin    = 1'b1;
            end else begin
              code_d = CODE_NEXT;
            end
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      req_q   <= 1'b0;
      copy_q  <= 1'b0;
      addr_q  <= '0;
      off_q   <= '0;
      len_q   <= '0;
      code_q  <= CODE_WAIT;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= done_d;
      code_q  <= code_d;
      if (take) begin
        copy_q <= copy_d;
        addr_q <= addr_d;
        off_q  <= off_d;
        len_q  <= len_d;
      end
    end
  end

  assign io_req_o     = req_q;
  assign io_copy_o    = copy_q;
  assign io_addr_o    = addr_q;
  assign io_offset_o  = off_q;
  assign io_len_o     = len_q;
  assign chunk_done_o = done_q;
  assign chunk_code_o = code_q;
endmodule

// File: rtl/ide_dma_seq_chk.sv
module ide_dma_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chunk_ready_o,
  input logic       chunk_done_o,
  input logic [1:0] chunk_code_o,
  input logic       io_req_o,
  input logic       io_done_i,
  input logic       io_err_i,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic       status_rd_i
);
  // R12: the interrupt only rises together with a final verdict
  p_irq_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (chunk_done_o && chunk_code_o[1]));

  // R12: without a status read the interrupt holds
  p_irq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !status_rd_i) |=> irq_o);

  // R8 / R9: a finished transfer shows ready and interrupt
  p_fin_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done_o && chunk_code_o == 2'd2) |-> (irq_o && status_o[6] && !status_o[0]));

  // R11: an error verdict shows the error bit and interrupt
  p_fail_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done_o && chunk_code_o == 2'd3) |-> (irq_o && status_o[0]));

  // R4: a request holds until completion or failure
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_o && !io_done_i && !io_err_i) |=> io_req_o);

  // R4: no new piece is taken while a request is outstanding
  p_req_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_o |-> !chunk_ready_o);
endmodule

bind ide_dma_seq ide_dma_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chunk_ready_o(chunk_ready_o),
  .chunk_done_o(chunk_done_o), .chunk_code_o(chunk_code_o),
  .io_req_o(io_req_o), .io_done_i(io_done_i), .io_err_i(io_err_i),
  .status_o(status_o), .irq_o(irq_o), .status_rd_i(status_rd_i)
);

// File: tb/tb_ide_dma_seq.sv
module tb_ide_dma_seq;
  localparam int SEC_W = 8, PKT_W = 16, LEN_W = 16, LBA_W = 20, ADDR_W = 32;
  localparam int OFF_W = LBA_W + 12;
  localparam longint LBA_ONES = (64'd1 << LBA_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, optical_i = 0, chunk_valid_i = 0, io_done_i = 0, io_err_i = 0, status_rd_i = 0;
  logic [SEC_W-1:0]  sectors_i = '0;
  logic [PKT_W-1:0]  packet_bytes_i = '0;
  logic [LBA_W-1:0]  lba_i = '0;
  logic [ADDR_W-1:0] chunk_addr_i = '0;
  logic [LEN_W-1:0]  chunk_len_i = '0;
  logic chunk_ready_o, chunk_done_o, io_req_o, io_copy_o, irq_o;
  logic [1:0] chunk_code_o;
  logic [ADDR_W-1:0] io_addr_o;
  logic [OFF_W-1:0]  io_offset_o;
  logic [LEN_W-1:0]  io_len_o;
  logic [7:0] status_o;

  always #5 clk = ~clk;

  ide_dma_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .optical_i(optical_i),
    .sectors_i(sectors_i), .packet_bytes_i(packet_bytes_i), .lba_i(lba_i),
    .chunk_valid_i(chunk_valid_i), .chunk_ready_o(chunk_ready_o),
    .chunk_addr_i(chunk_addr_i), .chunk_len_i(chunk_len_i),
    .chunk_done_o(chunk_done_o), .chunk_code_o(chunk_code_o),
    .io_req_o(io_req_o), .io_copy_o(io_copy_o), .io_addr_o(io_addr_o),
    .io_offset_o(io_offset_o), .io_len_o(io_len_o), .io_done_i(io_done_i),
    .io_err_i(io_err_i), .status_o(status_o), .irq_o(irq_o),
    .status_rd_i(status_rd_i)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0;

  longint m_rem, m_idx, m_lba;
  bit m_act = 0, m_opt = 0, m_irq = 0;
  longint m_stat = 0;
  int n_pieces;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_start(bit opt, int secs, int pkt, longint lba);
    @(negedge clk);
    start_i = 1; optical_i = opt; sectors_i = SEC_W'(secs);
    packet_bytes_i = PKT_W'(pkt); lba_i = LBA_W'(lba);
    @(negedge clk);
    start_i = 0;
    m_rem = opt ? pkt : secs * 512; m_idx = 0; m_lba = lba; m_act = 1; m_opt = opt;
    n_pieces = 0;
  endtask

  task automatic finish_model();
    m_act = 0; m_irq = 1;
    m_stat = m_opt ? 'h40 : 'h50;
  endtask

  task automatic check_status(string tag);
    check({tag, " status"}, status_o, m_stat);
    check({tag, " irq"}, irq_o, m_irq);
  endtask

  task automatic do_piece(int len, bit err, bit rd_same);
    bit raw;
    longint exp_len, exp_off;
    @(negedge clk);
    chunk_valid_i = 1; chunk_len_i = LEN_W'(len); chunk_addr_i = ADDR_W'(32'h1000 + len);
    @(negedge clk);
    chunk_valid_i = 0;
    raw = m_opt && (m_lba == LBA_ONES);
    if (!m_act) begin
      check("R3 wait verdict", {chunk_done_o, chunk_code_o}, 3'b100);
      check("R3 no request", io_req_o, 0);
      check_status("R3");
    end else if (m_rem == 0) begin
      finish_model();
      check("R13 immediate finish", {chunk_done_o, chunk_code_o, io_req_o}, 4'b1100);
      check_status("R13");
    end else if (len == 0) begin
      check("R7 zero piece", {chunk_done_o, chunk_code_o, io_req_o}, 4'b1010);
      check_status("R7");
    end else begin
      exp_len = raw ? ((len < m_rem) ? len : m_rem) : len;
      exp_off = raw ? 0 : (m_lba << (m_opt ? 11 : 9)) + m_idx;
      check("R4 request up", {io_req_o, chunk_done_o}, 2'b10);
      check("R4 request addr", io_addr_o, 32'h1000 + len);
      if (raw) begin
        check("R10 copy flag", io_copy_o, 1);
        check("R10 copy len", io_len_o, exp_len);
        check("R10 copy offset", io_offset_o, 0);
      end else begin
        check("R4 copy flag", io_copy_o, 0);
        check("R4 length", io_len_o, exp_len);
        check(m_opt ? "R5 optical offset" : "R4 disk offset", io_offset_o, exp_off);
      end
      if (err) io_err_i = 1; else io_done_i = 1;
      status_rd_i = rd_same;
      @(negedge clk);
      io_err_i = 0; io_done_i = 0; status_rd_i = 0;
      n_pieces++;
      if (err) begin
        m_act = 0; m_irq = 1; m_stat = 'h41;
        check("R11 fail verdict", {chunk_done_o, chunk_code_o, io_req_o}, 4'b1110);
        check_status("R11");
      end else if (raw) begin
        finish_model();
        check("R10 copy finishes", {chunk_done_o, chunk_code_o, io_req_o}, 4'b1100);
        check_status("R9");
      end else begin
        m_rem = (len >= m_rem) ? 0 : m_rem - len;
        m_idx += len;
        if (m_rem == 0) begin
          finish_model();
          check("R6 final verdict", {chunk_done_o, chunk_code_o, io_req_o}, 4'b1100);
          check_status(m_opt ? "R9" : "R8");
        end else begin
          check("R6 piece over", {chunk_done_o, chunk_code_o, io_req_o}, 4'b1010);
          check_status("R6");
        end
      end
    end
  endtask

  task automatic do_read();
    @(negedge clk);
    status_rd_i = 1;
    @(negedge clk);
    status_rd_i = 0;
    m_irq = 0;
    check("R12 read clears irq", irq_o, 0);
  endtask

  task automatic run_until_done(int pat, int fixed);
    for (int k = 0; k < 60 && m_act; k++) begin
      if (pat == 2) do_piece((k % 2 == 0) ? 0 : 700, 0, 0);
      else do_piece(fixed, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status", status_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 outputs", {chunk_done_o, io_req_o, chunk_ready_o}, 3'b001);

    // disk sweep: sizes x piece patterns
    for (int secs = 1; secs <= 3; secs++) begin
      for (int pat = 0; pat < 3; pat++) begin
        int plen;
        plen = (pat == 0) ? 512 : (pat == 1) ? 300 : 700;
        do_start(0, secs, 0, 1000 + secs * 7 + pat);
        run_until_done(pat, plen);
        check("R2 pieces to finish", n_pieces, (secs * 512 + plen - 1) / plen);
        do_piece(512, 0, 0);
        do_read();
      end
    end

    // zero sectors
    do_start(0, 0, 0, 5);
    do_piece(512, 0, 0);
    do_read();

    // optical block transfers
    for (int p = 0; p < 3; p++) begin
      int pk;
      pk = (p == 0) ? 100 : (p == 1) ? 2048 : 5000;
      for (int q = 0; q < 2; q++) begin
        do_start(1, 0, pk, 33 + p);
        run_until_done(0, (q == 0) ? 2048 : 1500);
        check("R2 optical pieces", n_pieces, (pk + ((q == 0) ? 2047 : 1499)) / ((q == 0) ? 2048 : 1500));
        do_read();
      end
    end

    // optical non-block copies: short and long packet
    do_start(1, 0, 100, LBA_ONES);
    do_piece(64, 0, 0);
    do_read();
    do_start(1, 0, 50, LBA_ONES);
    do_piece(0, 0, 0);
    do_piece(64, 0, 0);
    do_read();

    // error mid transfer
    do_start(0, 4, 0, 77);
    do_piece(512, 0, 0);
    do_piece(512, 1, 0);
    do_piece(512, 0, 0);
    do_read();

    // read in same cycle as completion
    do_start(0, 1, 0, 9);
    do_piece(512, 0, 1);
    check("R12 set wins over read", irq_o, 1);
    do_read();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule